// File: doc/BRIEF.md
# Class-Steered Dispatch Buffer

This block sits between an eight-wide register-rename stage and three scheduler classes: integer, floating point and load/store. Each cycle rename offers a group of up to eight micro-ops. Each slot of the group carries its own valid bit and a two-bit class code. The buffer takes the whole group in one cycle. It steers every micro-op into one of three circular queues, one per class, and keeps program order inside each class.

Each queue presents its oldest entries to its scheduler on a narrower drain port. The integer port is six wide and the floating-point and load/store ports are four wide. Every drain slot has its own valid and ready. Because each queue holds 64 entries, a burst of about fifty micro-ops of one class moves through without holding back the front end, even though that class drains at half the input rate. A flush input empties all three queues at once. Each queue's occupancy is brought out as a port.

Top module: `dispatch_buffer`

## Requirements
- R1: After reset all three occupancies are zero, no drain slot is valid, and in_ready is high while flush is low.
- R2: A valid slot whose class code is 0 goes to the integer queue, code 1 to the floating-point queue and code 2 to the load/store queue. A valid slot with code 3 is discarded and changes no occupancy.
- R3: Within one class, micro-ops leave in program order. Inside a group, a lower slot index is older. Any micro-op of an earlier accepted group is older than every micro-op of a later group.
- R4: Drain slot k of a queue is valid exactly when k is below both that queue's port width (integer 6, floating point 4, load/store 4) and its occupancy. Slot k then carries the k-th oldest entry.
- R5: The number of entries consumed in a cycle is the length of the unbroken run of slots, starting at slot 0, in which both valid and ready are high. A ready on a slot that lies after a break in that run removes nothing.
- R6: in_ready is high exactly when flush is low and, for every class, the free space (64 minus occupancy) is at least the number of valid slots of that class in the current group. A group is stored completely when in_ready is high and not at all otherwise.
- R7: When flush is high, all three occupancies read zero in the next cycle. The flush overrides any enqueue or drain in the same cycle, and in_ready is low while flush is high.
- R8: Each occupancy port, one cycle after an edge, equals its previous value plus the micro-ops stored for that class minus those consumed.
- R9: Seven back-to-back groups of eight load/store micro-ops, drained four per cycle, are all accepted with in_ready high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties all queues |
| in_vld | input | 8 | Per-slot valid of the incoming group |
| in_cls | input | 16 | Two-bit class code per slot, slot i at bits 2i+1:2i |
| in_data | input | 128 | Payload per slot, slot i at bits 16i+15:16i |
| in_ready | output | 1 | Group accepted this cycle |
| int_vld | output | 6 | Integer drain slot valid |
| int_data | output | 96 | Integer drain payloads |
| int_rdy | input | 6 | Integer drain slot ready |
| fp_vld | output | 4 | Floating-point drain slot valid |
| fp_data | output | 64 | Floating-point drain payloads |
| fp_rdy | input | 4 | Floating-point drain slot ready |
| ls_vld | output | 4 | Load/store drain slot valid |
| ls_data | output | 64 | Load/store drain payloads |
| ls_rdy | input | 4 | Load/store drain slot ready |
| int_cnt | output | 7 | Integer queue occupancy |
| fp_cnt | output | 7 | Floating-point queue occupancy |
| ls_cnt | output | 7 | Load/store queue occupancy |

## Verification
The bench fills the integer queue to exactly 64 entries and then offers one more integer group, which has to be refused. It then offers a group that holds only floating-point work, which has to be accepted. A design that checked total space, or that accepted part of a group, would store a wrong number of entries and show it on the occupancy ports. Ready patterns with holes test that nothing past a break is consumed; a design that popped every ready slot would lose micro-ops and reorder the payloads that follow. Flushes that coincide with a valid group and active drains test that the queues end up empty. Any stray enqueue would show up as a non-zero occupancy. A seven-cycle load/store burst tests that ready stays high while one class is filling.

// File: rtl/dispatch_buffer.sv
module dispatch_buffer #(
  parameter int DW    = 16,
  parameter int IN_W  = 8,
  parameter int INT_W = 6,
  parameter int FP_W  = 4,
  parameter int LS_W  = 4,
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [IN_W-1:0]     in_vld,
  input  logic [2*IN_W-1:0]   in_cls,
  input  logic [IN_W*DW-1:0]  in_data,
  output logic                in_ready,
  output logic [INT_W-1:0]    int_vld,
  output logic [INT_W*DW-1:0] int_data,
  input  logic [INT_W-1:0]    int_rdy,
  output logic [FP_W-1:0]     fp_vld,
  output logic [FP_W*DW-1:0]  fp_data,
  input  logic [FP_W-1:0]     fp_rdy,
  output logic [LS_W-1:0]     ls_vld,
  output logic [LS_W*DW-1:0]  ls_data,
  input  logic [LS_W-1:0]     ls_rdy,
  output logic [CW-1:0]       int_cnt,
  output logic [CW-1:0]       fp_cnt,
  output logic [CW-1:0]       ls_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int MW = (INT_W > FP_W) ? ((INT_W > LS_W) ? INT_W : LS_W)
                                     : ((FP_W > LS_W) ? FP_W : LS_W);

  logic [2:0]                room;
  logic [2:0][MW-1:0]        ov, ordy;
  logic [2:0][MW*DW-1:0]     od;
  logic [2:0][CW-1:0]        cnt;

  assign in_ready = (&room) && !flush;

  assign ordy[0] = MW'(int_rdy);
  assign ordy[1] = MW'(fp_rdy);
  assign ordy[2] = MW'(ls_rdy);

  assign int_vld  = ov[0][INT_W-1:0];
  assign fp_vld   = ov[1][FP_W-1:0];
  assign ls_vld   = ov[2][LS_W-1:0];
  assign int_data = od[0][INT_W*DW-1:0];
  assign fp_data  = od[1][FP_W*DW-1:0];
  assign ls_data  = od[2][LS_W*DW-1:0];
  assign int_cnt  = cnt[0];
  assign fp_cnt   = cnt[1];
  assign ls_cnt   = cnt[2];

  for (genvar c = 0; c < 3; c++) begin : g_q
    localparam int OW = (c == 0) ? INT_W : (c == 1) ? FP_W : LS_W;

    logic [DW-1:0]            mem [DEPTH];
    logic [AW-1:0]            rp, wp;
    logic [IN_W-1:0]          hit;
    logic [IN_W-1:0][AW-1:0]  pos;
    logic [CW-1:0]            nin, npop;

    always_comb begin
      int k;
      k = 0;
      for (int i = 0; i < IN_W; i++) begin
        hit[i] = in_vld[i] && (in_cls[2*i +: 2] == 2'(c));
        pos[i] = AW'(k);
        if (hit[i]) k++;
      end
      nin = CW'(k);
    end

    always_comb begin
      logic run;
      run  = 1'b1;
      npop = '0;
      for (int k = 0; k < OW; k++) begin
        if (run && ov[c][k] && ordy[c][k]) npop = npop + 1'b1;
        else run = 1'b0;
      end
    end

    assign room[c] = (int'(cnt[c]) + int'(nin)) <= DEPTH;

    for (genvar k = 0; k < MW; k++) begin : g_out
      assign ov[c][k] = (k < OW) && (int'(cnt[c]) > k);
      assign od[c][k*DW +: DW] = mem[rp + AW'(k)];
    end

    always_ff @(posedge clk) begin
      if (in_ready) begin
        for (int i = 0; i < IN_W; i++)
          if (hit[i]) mem[wp + pos[i]] <= in_data[i*DW +: DW];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        rp     <= '0;
        wp     <= '0;
        cnt[c] <= '0;
      end else begin
        rp     <= rp + AW'(npop);
        wp     <= wp + (in_ready ? AW'(nin) : '0);
        cnt[c] <= cnt[c] + (in_ready ? nin : '0) - npop;
      end
    end
  end
endmodule

module dispatch_buffer_chk #(
  parameter int DW    = 16,
  parameter int IN_W  = 8,
  parameter int INT_W = 6,
  parameter int FP_W  = 4,
  parameter int LS_W  = 4,
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                flush,
  input logic                in_ready,
  input logic [INT_W-1:0]    int_vld,
  input logic [INT_W*DW-1:0] int_data,
  input logic [INT_W-1:0]    int_rdy,
  input logic [FP_W-1:0]     fp_vld,
  input logic [CW-1:0]       int_cnt,
  input logic [CW-1:0]       fp_cnt,
  input logic [CW-1:0]       ls_cnt
);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(int_cnt) <= DEPTH && int'(fp_cnt) <= DEPTH && int'(ls_cnt) <= DEPTH);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (int_cnt == '0 && fp_cnt == '0 && ls_cnt == '0));

  a_r7_flush_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

  a_r4_int_valid_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(int_vld) == ((int'(int_cnt) >= INT_W) ? INT_W : int'(int_cnt)));

  a_r4_int_valid_packed: assert property (@(posedge clk) disable iff (!rst_n)
    (int_vld & INT_W'(int_vld + 1'b1)) == '0);

  a_r4_fp_valid_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fp_vld) == ((int'(fp_cnt) >= FP_W) ? FP_W : int'(fp_cnt)));

  a_r3_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (int_vld[0] && !int_rdy[0] && !flush) |=> $stable(int_data[DW-1:0]));
endmodule

bind dispatch_buffer dispatch_buffer_chk #(
  .DW(DW), .IN_W(IN_W), .INT_W(INT_W), .FP_W(FP_W), .LS_W(LS_W), .DEPTH(DEPTH)
) chk_i (.*);

// File: tb/dispatch_buffer_tb.sv
module dispatch_buffer_tb_top;
  localparam int DW = 16;
  logic clk = 0, rst_n = 0, flush = 0;
  logic [7:0]   in_vld = '0;
  logic [15:0]  in_cls = '0;
  logic [127:0] in_data = '0;
  logic         in_ready;
  logic [5:0]   int_vld, int_rdy = '0;
  logic [95:0]  int_data;
  logic [3:0]   fp_vld, fp_rdy = '0, ls_vld, ls_rdy = '0;
  logic [63:0]  fp_data, ls_data;
  logic [6:0]   int_cnt, fp_cnt, ls_cnt;

  int checks = 0, errors = 0;
  logic [DW-1:0] mq [3][$];
  string rtag = "R6", ctag = "R8";
  int ow [3] = '{6, 4, 4};

  always #5 clk = ~clk;

  dispatch_buffer dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic vbit(int c, int k);
    case (c) 0: return int_vld[k]; 1: return fp_vld[k]; default: return ls_vld[k]; endcase
  endfunction
  function automatic logic rbit(int c, int k);
    case (c) 0: return int_rdy[k]; 1: return fp_rdy[k]; default: return ls_rdy[k]; endcase
  endfunction
  function automatic logic [DW-1:0] dslot(int c, int k);
    case (c) 0: return int_data[k*DW +: DW]; 1: return fp_data[k*DW +: DW];
      default: return ls_data[k*DW +: DW]; endcase
  endfunction
  function automatic int ocnt(int c);
    case (c) 0: return int'(int_cnt); 1: return int'(fp_cnt); default: return int'(ls_cnt); endcase
  endfunction

  task automatic step();
    int nin [3];
    int np [3];
    logic exp_rdy;
    logic gap;
    #1;
    exp_rdy = !flush;
    gap = 0;
    for (int c = 0; c < 3; c++) begin
      nin[c] = 0;
      for (int i = 0; i < 8; i++) if (in_vld[i] && in_cls[2*i +: 2] == 2'(c)) nin[c]++;
      if (64 - mq[c].size() < nin[c]) exp_rdy = 0;
    end
    chk(flush ? "R7" : rtag, in_ready, exp_rdy);
    for (int c = 0; c < 3; c++) begin
      logic run;
      chk(ctag, ocnt(c), mq[c].size());
      for (int k = 0; k < ow[c]; k++) begin
        chk("R4", vbit(c, k), k < mq[c].size());
        if (k < mq[c].size()) chk("R3", dslot(c, k), mq[c][k]);
      end
      run = 1; np[c] = 0;
      for (int k = 0; k < ow[c]; k++) begin
        if (run && k < mq[c].size() && rbit(c, k)) np[c]++;
        else begin
          if (run && k < mq[c].size() && k + 1 < mq[c].size()) gap = 1;
          run = 0;
        end
      end
    end
    @(posedge clk);
    if (flush) begin
      for (int c = 0; c < 3; c++) mq[c].delete();
    end else begin
      for (int c = 0; c < 3; c++) repeat (np[c]) void'(mq[c].pop_front());
      if (exp_rdy)
        for (int i = 0; i < 8; i++)
          if (in_vld[i] && in_cls[2*i +: 2] != 2'd3) mq[in_cls[2*i +: 2]].push_back(in_data[i*DW +: DW]);
    end
    ctag = flush ? "R7" : (gap ? "R5" : "R8");
    @(negedge clk);
  endtask

  task automatic group(logic [7:0] v, logic [15:0] cls);
    in_vld = v; in_cls = cls;
    for (int i = 0; i < 8; i++) in_data[i*DW +: DW] = DW'($urandom);
  endtask

  task automatic idle_drain();
    group(8'h00, '0); flush = 0; int_rdy = '1; fp_rdy = '1; ls_rdy = '1;
    repeat (20) step();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk("R1", in_ready, 1);
    chk("R1", {int_cnt, fp_cnt, ls_cnt}, 0);
    chk("R1", {int_vld, fp_vld, ls_vld}, 0);
    @(negedge clk);

    group(8'hFF, 16'b11_10_01_00_11_10_01_00);
    step();
    group(8'h00, '0);
    #1;
    chk("R2", int_cnt, 2); chk("R2", fp_cnt, 2); chk("R2", ls_cnt, 2);
    step();
    idle_drain();

    for (int n = 0; n < 400; n++) begin
      group(8'($urandom), 16'($urandom));
      int_rdy = 6'($urandom | $urandom); fp_rdy = 4'($urandom); ls_rdy = 4'($urandom & $urandom);
      flush = ($urandom % 40) == 0;
      step();
    end
    idle_drain();

    rtag = "R9";
    ls_rdy = '1; int_rdy = '0; fp_rdy = '0;
    repeat (7) begin group(8'hFF, 16'hAAAA); step(); end
    rtag = "R6";
    idle_drain();

    int_rdy = '0; fp_rdy = '0; ls_rdy = '0;
    repeat (9) begin group(8'hFF, 16'h0000); step(); end
    group(8'hFF, 16'h5555); step();
    group(8'h03, 16'h0004); step();

    int_rdy = 6'b111011; step();
    int_rdy = 6'b000010; step();
    int_rdy = '0;
    group(8'hFF, 16'h9C63); flush = 1; ls_rdy = '1; step();
    flush = 0; group(8'h00, '0); step();
    idle_drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule